// File: doc/BRIEF.md
# Hashed Page Table Search Engine

This block looks up a translation entry in a hashed page table that lives in a word-addressed memory. A search starts with a 24-bit segment identifier, an effective address and the value of the table base register. From these the engine computes a primary entry group and a secondary entry group, then reads the first word of every slot in both groups through a synchronous memory read port. It compares each word against a compare word that it builds from the segment identifier and the address.

Each group holds eight two-word entries. All sixteen first words are always read, so a second matching entry can be reported as a duplicate. The first match in scan order wins. Only for that slot is the second word fetched. At the end the block gives a one-cycle done pulse with hit, group, slot, both entry words and the duplicate flag. These results hold until the next search is accepted. Writing and updating entries is left to other logic.

Top module: `pt_search`

## Requirements
- R1: While rst_ni is low and after its release, busy_o, done_o, hit_o, dup_o and mem_rd_o are 0, and word0_o and word1_o are 0.
- R2: From the table register, the hash mask is the 19-bit value {reg[8:0], 10'h3FF} and the table base is reg with bits 15:0 cleared. A group byte address is the base ORed with its group offset.
- R3: The primary hash is ea[27:12] zero-extended to 19 bits, XOR vsid[18:0]. The primary group offset in bytes is (hash AND mask) shifted left by 6.
- R4: A slot matches only when its first word equals {1, vsid[23:0], h, ea[27:22]}, with the valid bit at 31, the segment ID at bits 30:7, the hash bit h at bit 6 and the page abbreviation at bits 5:0. h is 0 in the primary group and 1 in the secondary group.
- R5: The secondary group offset is the primary offset XOR (mask shifted left by 6).
- R6: After a start, exactly one read is issued per cycle for 16 cycles. The reads cover primary slots 0 to 7 and then secondary slots 0 to 7. The word address of slot s is the group byte address divided by 4, plus 2*s.
- R7: On a hit, hit_o=1 and the first matching slot in scan order is reported: secondary_o shows the group, slot_o the slot and word0_o the matched first word.
- R8: On a hit, exactly one more read is issued, at word address (first word address + 1) of the winning slot, and its data is returned on word1_o. On a miss no further read is issued.
- R9: When no slot matches, done_o pulses with hit_o=0, word0_o=0 and word1_o=0. This happens 19 cycles after the start edge.
- R10: dup_o is 1 exactly when more than one of the 16 slots match. It is never 1 on a miss.
- R11: On a hit, done_o pulses 20 cycles after the start edge. done_o lasts one cycle, and the results stay unchanged afterwards until the next accepted start.
- R12: A start_i pulse while busy_o is 1 is ignored. The current search keeps its reads and its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a search (accepted when idle) |
| vsid_i | input | 24 | Segment identifier |
| ea_i | input | 32 | Effective address |
| tbl_reg_i | input | 32 | Table base register value (base and mask size) |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle result pulse |
| hit_o | output | 1 | A matching entry was found |
| secondary_o | output | 1 | Match found in the secondary group |
| slot_o | output | 3 | Slot index of the match |
| dup_o | output | 1 | More than one slot matched |
| word0_o | output | 32 | First word of the matched entry |
| word1_o | output | 32 | Second word of the matched entry |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 30 | Memory word address |
| mem_rdata_i | input | 32 | Read data, valid the cycle after the strobe |

## Verification
The bench builds the block with its default eight slots per group. It runs the search with three table register values: the smallest table, a four-times table at a base with high bits set, and the largest mask with all nine size bits set. For each of these it uses two segment and address pairs. For every pair it sweeps one matching entry over all sixteen slot positions, plus a case with no match. The other slots hold decoys that differ only in the valid bit, the hash bit or one segment bit. Together these sweeps cover every scan position, both hash bit values, every decoy kind in both groups, and mask bits at every width. Two extra searches cover the duplicate cases, and one more sends a start pulse in the middle of a search.

// File: rtl/pt_search_pkg.sv
package pt_search_pkg;
  localparam int VSID_W = 24;
  localparam int WORD_W = 32;
  localparam int HASH_W = 19;
  localparam int PIDX_W = 16;
  localparam int MEM_AW = 30;
  localparam int HBIT   = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_DRAIN,
    ST_DECIDE,
    ST_WAIT1
  } state_e;
endpackage

// File: rtl/pt_hash.sv
module pt_hash
  import pt_search_pkg::*;
#(
  parameter int GRP_SH = 6
) (
  input  logic [VSID_W-1:0] vsid_i,
  input  logic [31:0]       ea_i,
  input  logic [31:0]       tbl_reg_i,
  output logic [MEM_AW-1:0] pri_grp_o,
  output logic [MEM_AW-1:0] sec_grp_o,
  output logic [WORD_W-1:0] cmp_o
);
  logic [HASH_W-1:0] mask, hash;
  logic [31:0] base, pri_off, sec_off, pri_b, sec_b;

  assign mask    = {tbl_reg_i[8:0], 10'h3FF};
  assign hash    = {{(HASH_W-PIDX_W){1'b0}}, ea_i[27:12]} ^ vsid_i[HASH_W-1:0];
  assign base    = {tbl_reg_i[31:16], 16'h0000};
  assign pri_off = 32'(hash & mask) << GRP_SH;
  assign sec_off = pri_off ^ (32'(mask) << GRP_SH);
  // table is aligned to its size, so OR acts as add
  assign pri_b   = base | pri_off;
  assign sec_b   = base | sec_off;
  assign pri_grp_o = pri_b[31:2];
  assign sec_grp_o = sec_b[31:2];
  assign cmp_o   = {1'b1, vsid_i, 1'b0, ea_i[27:22]};

  logic unused_bits;
  assign unused_bits = ^{pri_b[1:0], sec_b[1:0], tbl_reg_i[15:9], ea_i[31:28], ea_i[21:0]};
endmodule

// File: rtl/pt_scan_ctl.sv
module pt_scan_ctl
  import pt_search_pkg::*;
#(
  parameter int SLOTS = 8,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int IDX_W  = SLOT_W + 1,
  localparam int NSCAN  = 2 * SLOTS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              found_i,
  input  logic [IDX_W-1:0]  hit_idx_i,
  input  logic [MEM_AW-1:0] pri_grp_i,
  input  logic [MEM_AW-1:0] sec_grp_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic              mem_rd_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic              rsp_v_o,
  output logic [IDX_W-1:0]  rsp_idx_o,
  output logic              w1_cap_o,
  output logic              done_o
);
  state_e state_q, state_d;
  logic [IDX_W-1:0] req_q;
  logic rsp_v_q, done_q;
  logic [IDX_W-1:0] rsp_idx_q;

  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign busy_o   = (state_q != ST_IDLE);
  assign w1_cap_o = (state_q == ST_WAIT1);

  always_comb begin
    mem_rd_o   = 1'b0;
    mem_addr_o = '0;
    state_d    = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_SCAN;
      ST_SCAN: begin
        mem_rd_o   = 1'b1;
        mem_addr_o = (req_q[SLOT_W] ? sec_grp_i : pri_grp_i)
                   | MEM_AW'({req_q[SLOT_W-1:0], 1'b0});
        if (req_q == IDX_W'(NSCAN - 1)) state_d = ST_DRAIN;
      end
      ST_DRAIN: state_d = ST_DECIDE;
      ST_DECIDE: begin
        if (found_i) begin
          mem_rd_o   = 1'b1;
          mem_addr_o = (hit_idx_i[SLOT_W] ? sec_grp_i : pri_grp_i)
                     | MEM_AW'({hit_idx_i[SLOT_W-1:0], 1'b1});
          state_d    = ST_WAIT1;
        end else begin
          state_d    = ST_IDLE;
        end
      end
      ST_WAIT1: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      req_q     <= '0;
      rsp_v_q   <= 1'b0;
      rsp_idx_q <= '0;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      rsp_v_q   <= (state_q == ST_SCAN);
      rsp_idx_q <= req_q;
      done_q    <= ((state_q == ST_DECIDE) && !found_i) || (state_q == ST_WAIT1);
      if (accept_o) req_q <= '0;
      else if (state_q == ST_SCAN) req_q <= req_q + 1'b1;
    end
  end

  assign rsp_v_o   = rsp_v_q;
  assign rsp_idx_o = rsp_idx_q;
  assign done_o    = done_q;

  AST_NO_READ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_rd_o); // R6
  AST_SCAN_STRIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SCAN && req_q[SLOT_W-1:0] != '0) |-> mem_addr_o == $past(mem_addr_o) + 2); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
endmodule

// File: rtl/pt_match.sv
module pt_match
  import pt_search_pkg::*;
#(
  parameter int SLOTS = 8,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int IDX_W  = SLOT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              rsp_v_i,
  input  logic [IDX_W-1:0]  rsp_idx_i,
  input  logic [WORD_W-1:0] rdata_i,
  input  logic [WORD_W-1:0] cmp_i,
  input  logic              w1_cap_i,
  output logic              found_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [WORD_W-1:0] word0_o,
  output logic [WORD_W-1:0] word1_o,
  output logic              dup_o
);
  logic [WORD_W-1:0] cmp_eff;
  logic match;
  logic found_q, dup_q;
  logic [IDX_W-1:0] idx_q;
  logic [WORD_W-1:0] w0_q, w1_q;

  assign cmp_eff = cmp_i | (WORD_W'(rsp_idx_i[SLOT_W]) << HBIT);
  assign match   = rsp_v_i && (rdata_i == cmp_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      found_q <= 1'b0;
      dup_q   <= 1'b0;
      idx_q   <= '0;
      w0_q    <= '0;
      w1_q    <= '0;
    end else if (clr_i) begin
      found_q <= 1'b0;
      dup_q   <= 1'b0;
      idx_q   <= '0;
      w0_q    <= '0;
      w1_q    <= '0;
    end else begin
      if (match) begin
        if (!found_q) begin
          found_q <= 1'b1;
          idx_q   <= rsp_idx_i;
          w0_q    <= rdata_i;
        end else begin
          dup_q   <= 1'b1;
        end
      end
      if (w1_cap_i) w1_q <= rdata_i;
    end
  end

  assign found_o = found_q;
  assign idx_o   = idx_q;
  assign word0_o = w0_q;
  assign word1_o = w1_q;
  assign dup_o   = dup_q;

  AST_FIRST_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (found_q && !clr_i) |=> (idx_q == $past(idx_q)) && (w0_q == $past(w0_q))); // R7
endmodule

// File: rtl/pt_search.sv
module pt_search
  import pt_search_pkg::*;
#(
  parameter int SLOTS = 8,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int IDX_W  = SLOT_W + 1,
  localparam int GRP_SH = SLOT_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [VSID_W-1:0] vsid_i,
  input  logic [31:0]       ea_i,
  input  logic [31:0]       tbl_reg_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              hit_o,
  output logic              secondary_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              dup_o,
  output logic [WORD_W-1:0] word0_o,
  output logic [WORD_W-1:0] word1_o,
  output logic              mem_rd_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  input  logic [WORD_W-1:0] mem_rdata_i
);
  logic [VSID_W-1:0] vsid_q;
  logic [31:0] ea_q, reg_q;
  logic accept, found, rsp_v, w1_cap;
  logic [IDX_W-1:0] hit_idx, rsp_idx;
  logic [MEM_AW-1:0] pri_grp, sec_grp;
  logic [WORD_W-1:0] cmp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vsid_q <= '0;
      ea_q   <= '0;
      reg_q  <= '0;
    end else if (accept) begin
      vsid_q <= vsid_i;
      ea_q   <= ea_i;
      reg_q  <= tbl_reg_i;
    end
  end

  pt_hash #(.GRP_SH(GRP_SH)) u_hash (
    .vsid_i    (vsid_q),
    .ea_i      (ea_q),
    .tbl_reg_i (reg_q),
    .pri_grp_o (pri_grp),
    .sec_grp_o (sec_grp),
    .cmp_o     (cmp)
  );

  pt_scan_ctl #(.SLOTS(SLOTS)) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .found_i    (found),
    .hit_idx_i  (hit_idx),
    .pri_grp_i  (pri_grp),
    .sec_grp_i  (sec_grp),
    .accept_o   (accept),
    .busy_o     (busy_o),
    .mem_rd_o   (mem_rd_o),
    .mem_addr_o (mem_addr_o),
    .rsp_v_o    (rsp_v),
    .rsp_idx_o  (rsp_idx),
    .w1_cap_o   (w1_cap),
    .done_o     (done_o)
  );

  pt_match #(.SLOTS(SLOTS)) u_match (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (accept),
    .rsp_v_i   (rsp_v),
    .rsp_idx_i (rsp_idx),
    .rdata_i   (mem_rdata_i),
    .cmp_i     (cmp),
    .w1_cap_i  (w1_cap),
    .found_o   (found),
    .idx_o     (hit_idx),
    .word0_o   (word0_o),
    .word1_o   (word1_o),
    .dup_o     (dup_o)
  );

  assign hit_o       = found;
  assign secondary_o = hit_idx[SLOT_W];
  assign slot_o      = hit_idx[SLOT_W-1:0];

  AST_HBIT_GROUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && hit_o) |-> (word0_o[HBIT] == secondary_o)); // R4
  AST_VALID_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && hit_o) |-> word0_o[WORD_W-1]); // R4
  AST_WORD1_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && hit_o) |-> ($past(mem_rd_o, 2) && $past(mem_addr_o[0], 2))); // R8
  AST_DUP_ON_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !hit_o) |-> !dup_o); // R10
  AST_MISS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !hit_o) |-> (word0_o == '0 && word1_o == '0)); // R9
endmodule

// File: tb/pt_search_tb.sv
`timescale 1ns/1ps
module pt_search_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [23:0] vsid_i = '0;
  logic [31:0] ea_i = '0, tbl_reg_i = '0;
  logic busy_o, done_o, hit_o, secondary_o, dup_o, mem_rd_o;
  logic [2:0] slot_o;
  logic [31:0] word0_o, word1_o, mem_rdata_i;
  logic [29:0] mem_addr_o;

  int n_cmp = 0;
  int n_bad = 0;

  logic [31:0] mem [int unsigned];

  always #4 clk_i = ~clk_i;

  pt_search u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .vsid_i(vsid_i),
    .ea_i(ea_i), .tbl_reg_i(tbl_reg_i), .busy_o(busy_o), .done_o(done_o),
    .hit_o(hit_o), .secondary_o(secondary_o), .slot_o(slot_o), .dup_o(dup_o),
    .word0_o(word0_o), .word1_o(word1_o), .mem_rd_o(mem_rd_o),
    .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i)
  );

  function automatic logic [31:0] mrd(logic [29:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 32'h0;
  endfunction

  always @(posedge clk_i) if (mem_rd_o) mem_rdata_i <= mrd(mem_addr_o);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] f_mask(logic [31:0] r);
    return {13'h0, r[8:0], 10'h3FF};
  endfunction

  function automatic logic [31:0] f_pgrp(logic [23:0] v, logic [31:0] e, logic [31:0] r);
    logic [31:0] h;
    h = {16'h0, e[27:12]} ^ {13'h0, v[18:0]};
    return {r[31:16], 16'h0} | ((h & f_mask(r)) << 6);
  endfunction

  function automatic logic [31:0] f_sgrp(logic [23:0] v, logic [31:0] e, logic [31:0] r);
    return {r[31:16], 16'h0} | (((f_pgrp(v, e, r) & 32'h0000_FFFF) | (f_pgrp(v, e, r) & ~{r[31:16], 16'h0}))
           ^ (f_mask(r) << 6));
  endfunction

  function automatic logic [31:0] f_cmp(logic [23:0] v, logic [31:0] e, bit h);
    return {1'b1, v, h, e[27:22]};
  endfunction

  // word address of slot p (0..7 primary, 8..15 secondary)
  function automatic int unsigned f_wa(logic [23:0] v, logic [31:0] e, logic [31:0] r, int p);
    logic [31:0] g;
    g = (p < 8) ? f_pgrp(v, e, r) : f_sgrp(v, e, r);
    return int'(g >> 2) + 2 * (p % 8);
  endfunction

  task automatic search(logic [23:0] v, logic [31:0] e, logic [31:0] r,
                        bit xh, bit xs, int xslot, logic [31:0] xw0, logic [31:0] xw1,
                        bit xdup, bit intrude, string tag);
    logic [29:0] got [$];
    int n;
    int nexp;
    bit ok;
    got.delete();
    vsid_i = v; ea_i = e; tbl_reg_i = r; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    vsid_i = ~v; ea_i = ~e; tbl_reg_i = 32'h0;
    n = 1;
    forever begin
      if (mem_rd_o) got.push_back(mem_addr_o);
      if (done_o || n > 60) break;
      if (intrude && n == 5) start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      n++;
    end
    chk(xh ? "R11" : "R9", {tag, " latency"}, 32'(n), xh ? 32'd20 : 32'd19);
    chk("R7", {tag, " hit"}, 32'(hit_o), 32'(xh));
    chk("R10", {tag, " dup"}, 32'(dup_o), 32'(xdup));
    chk(xh ? "R7" : "R9", {tag, " word0"}, word0_o, xh ? xw0 : 32'h0);
    chk("R8", {tag, " word1"}, word1_o, xh ? xw1 : 32'h0);
    if (xh) begin
      chk("R7", {tag, " group"}, 32'(secondary_o), 32'(xs));
      chk("R7", {tag, " slot"}, 32'(slot_o), 32'(xslot));
    end
    nexp = xh ? 17 : 16;
    chk(intrude ? "R12" : "R6", {tag, " reads"}, 32'(got.size()), 32'(nexp));
    ok = (got.size() == nexp);
    for (int i = 0; i < 16 && ok; i++)
      if (int'(got[i]) != f_wa(v, e, r, i)) ok = 0;
    if (ok && xh && int'(got[16]) != f_wa(v, e, r, xs ? xslot + 8 : xslot) + 1) ok = 0;
    chk("R6", {tag, " addr order R3 R5 R2"}, 32'(ok), 32'd1);
    @(negedge clk_i);
    chk("R11", {tag, " pulse"}, 32'(done_o), 32'd0);
    chk("R11", {tag, " held"}, {word0_o[30:0], hit_o}, {(xh ? xw0[30:0] : 31'h0), xh});
  endtask

  task automatic fill(logic [23:0] v, logic [31:0] e, logic [31:0] r, int p0, int p1);
    mem.delete();
    for (int s = 0; s < 16; s++) begin
      logic [31:0] c;
      c = f_cmp(v, e, s >= 8);
      if (s == p0 || s == p1) begin
        mem[f_wa(v, e, r, s)]     = c;
        mem[f_wa(v, e, r, s) + 1] = 32'hC0DE_0000 | 32'(s);
      end else begin
        // R4 decoys: valid clear, wrong hash bit, one segment bit flipped
        case (s % 3)
          0: mem[f_wa(v, e, r, s)] = c & 32'h7FFF_FFFF;
          1: mem[f_wa(v, e, r, s)] = c ^ 32'h0000_0040;
          default: mem[f_wa(v, e, r, s)] = c ^ 32'h0000_0080;
        endcase
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL R9 watchdog act=timeout exp=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] regs [3];
    regs[0] = 32'h0001_0000;
    regs[1] = 32'h0084_0003;
    regs[2] = 32'h0E00_01FF;
    repeat (3) @(negedge clk_i);
    chk("R1", "reset outs", {26'h0, busy_o, done_o, hit_o, dup_o, mem_rd_o, 1'b0}, 32'h0);
    chk("R1", "reset words", word0_o | word1_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "post reset", {28'h0, busy_o, done_o, hit_o, mem_rd_o}, 32'h0);
    for (int b = 0; b < 3; b++) begin
      for (int k = 0; k < 2; k++) begin
        logic [23:0] v;
        logic [31:0] e;
        v = 24'h5A3C11 + 24'(k) * 24'h1F7B3D + 24'(b) * 24'h00A001;
        e = 32'h1234_5678 ^ (32'(k) * 32'h0F0F_1000) ^ (32'(b) * 32'h0030_7000);
        for (int p = 0; p <= 16; p++) begin
          fill(v, e, regs[b], p, -1);
          if (p == 16)
            search(v, e, regs[b], 0, 0, 0, 0, 0, 0, 0, "R9 miss");
          else
            search(v, e, regs[b], 1, p >= 8, p % 8, f_cmp(v, e, p >= 8),
                   32'hC0DE_0000 | 32'(p), 0, 0, "R7 sweep");
        end
      end
    end
    fill(24'h00BEEF, 32'h0ABC_D000, regs[1], 2, 13);
    search(24'h00BEEF, 32'h0ABC_D000, regs[1], 1, 0, 2, f_cmp(24'h00BEEF, 32'h0ABC_D000, 0),
           32'hC0DE_0002, 1, 0, "R10 dup pri/sec");
    fill(24'h7F0001, 32'h0555_5000, regs[2], 3, 6);
    search(24'h7F0001, 32'h0555_5000, regs[2], 1, 0, 3, f_cmp(24'h7F0001, 32'h0555_5000, 0),
           32'hC0DE_0003, 1, 0, "R10 dup pri/pri");
    fill(24'h123456, 32'h0765_4000, regs[0], 12, -1);
    search(24'h123456, 32'h0765_4000, regs[0], 1, 1, 4, f_cmp(24'h123456, 32'h0765_4000, 1),
           32'hC0DE_000C, 0, 1, "R12 start while busy");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule